// File: doc/BRIEF.md
# Arithmetic-Code Encoder and Output Checker

This block sits at the boundary of a processor that computes only on arithmetic-coded data. On the way in, it turns a 32-bit plain value into a 64-bit code word. The code word is the value times a fixed odd multiplier A, plus a per-variable signature taken from an internal table, plus a running iteration stamp. On the way out, it takes a 64-bit result and an index naming the signature that the result should carry. It removes the current stamp and divides by A. It then compares the remainder with the expected signature. A word whose remainder differs is flagged, and so is a word built with a stale stamp. A word that matches is released as its quotient.

The stamp is a counter. A strobe at the end of every program iteration advances it, and it wraps at its width. The signature table is loaded through a write port. A value that is not strictly below A is refused, so every stored signature stays a legal residue. Any mismatch latches a sticky error flag. While that flag is set, no decoded value is released, until software clears it. The remainder and quotient come from a serial restoring divider that produces one quotient bit per clock.

Top module: `arith_code_unit`

## Requirements
- R1: After reset the stamp is 0, every table entry is 0, and `enc_valid`, `chk_busy`, `chk_done`, `chk_pass`, `chk_mismatch` and `err_sticky` are low.
- R2: Each clock edge with `cycle_end` high adds 1 to `ts_value`, modulo 2^TS_W. Without the strobe the stamp holds.
- R3: One clock after a cycle with `enc_req` high, `enc_valid` is high and `enc_word` = A*`enc_value` + table[`enc_sel`] + stamp, using the stamp as it stood in the request cycle.
- R4: A table write with `sig_wdata` < A replaces the entry at `sig_waddr`. A write with `sig_wdata` >= A leaves the entry unchanged.
- R5: An accepted check raises `chk_busy` from the next cycle. `chk_done` pulses for one cycle exactly CW+1 clocks after the accepting edge (65 with CW = 64).
- R6: When (`chk_word` - stamp at acceptance) mod A differs from table[`chk_sel`], the done cycle shows `chk_mismatch`=1, `chk_pass`=0 and `chk_value`=0. This covers a word encoded under an older stamp.
- R7: When the remainder matches and the sticky flag is clear, the done cycle shows `chk_pass`=1, `chk_mismatch`=0 and `chk_value` = low FW bits of (`chk_word` - stamp) / A.
- R8: A mismatch sets `err_sticky`, and it stays set until an `err_clr` cycle. While it is set, a matching word gives `chk_pass`=0 and `chk_value`=0.
- R9: `chk_start` while `chk_busy` is high is ignored. It produces no extra `chk_done`, and it does not alter the result under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | End-of-iteration strobe, advances the stamp |
| ts_value | output | TS_W | Current iteration stamp |
| sig_we | input | 1 | Signature table write enable |
| sig_waddr | input | IDX_W | Table entry to write |
| sig_wdata | input | A_W | Signature value, must be below A |
| enc_req | input | 1 | Encode request |
| enc_sel | input | IDX_W | Signature index for the encode |
| enc_value | input | FW | Plain value to encode |
| enc_valid | output | 1 | Encoded word valid |
| enc_word | output | CW | Encoded word |
| chk_start | input | 1 | Start a check when idle |
| chk_sel | input | IDX_W | Expected signature index |
| chk_word | input | CW | Encoded result to check |
| chk_busy | output | 1 | Divider running |
| chk_done | output | 1 | One-cycle result pulse |
| chk_pass | output | 1 | Word valid and released |
| chk_mismatch | output | 1 | Residue differs from expected signature |
| chk_value | output | FW | Decoded value, 0 unless released |
| err_clr | input | 1 | Clears the sticky error flag |
| err_sticky | output | 1 | Latched mismatch flag |

## Verification
The encoded word is due one clock after the request. The bench drives at the falling edge and reads the word at the next falling edge, so exactly one rising edge lies between them. A check result is due CW+1 rising edges after the accepting edge. The bench counts falling edges from acceptance until `chk_done` appears, and it compares that count with 65 as well as comparing the result fields. The stamp is advanced by bench-driven strobes, so the expected stamp is always known when a stale-stamp word or a busy-time restart is applied.

// File: rtl/acu_pkg.sv
package acu_pkg;

   typedef enum logic [0:0] {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/acu_sig_table.sv
module acu_sig_table #(
   parameter int               DEPTH  = 16,
   parameter int               A_W    = 32,
   parameter longint unsigned  MULT_A = 58659,
   localparam int              IDX_W  = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [A_W-1:0]   wr_sig,
   input  logic [IDX_W-1:0] rd_idx_a,
   output logic [A_W-1:0]   rd_sig_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [A_W-1:0]   rd_sig_b
);
   localparam logic [A_W-1:0] A_VEC = A_W'(MULT_A);

   logic [A_W-1:0] entry_q [DEPTH];
   logic           wr_legal;

   // only residues strictly below A may enter the table
   assign wr_legal = wr_en && (wr_sig < A_VEC);

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry_q[gi] <= '0;
         else if (wr_legal && (wr_idx == IDX_W'(gi)))
            entry_q[gi] <= wr_sig;
      end
   end

   assign rd_sig_a = entry_q[rd_idx_a];
   assign rd_sig_b = entry_q[rd_idx_b];

endmodule

// File: rtl/acu_encoder.sv
module acu_encoder #(
   parameter int               FW       = 32,
   parameter int               CW       = 64,
   parameter int               A_W      = 32,
   parameter int               TS_W     = 16,
   parameter longint unsigned  MULT_A   = 58659,
   parameter bit               ENC_PIPE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [FW-1:0]   value,
   input  logic [A_W-1:0]  sig,
   input  logic [TS_W-1:0] stamp,
   output logic            valid,
   output logic [CW-1:0]   word
);
   localparam logic [CW-1:0] A_WIDE = CW'(MULT_A);

   logic [CW-1:0] word_d;

   assign word_d = (A_WIDE * CW'(value)) + CW'(sig) + CW'(stamp);

   if (ENC_PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
         end else begin
            valid <= req;
            if (req)
               word <= word_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign valid = req;
      assign word  = word_d;
   end

endmodule

// File: rtl/acu_divider.sv
module acu_divider
   import acu_pkg::*;
#(
   parameter int               CW     = 64,
   parameter int               A_W    = 32,
   parameter longint unsigned  MULT_A = 58659
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [CW-1:0]  dividend,
   output logic           busy,
   output logic           done,
   output logic [CW-1:0]  quotient,
   output logic [A_W-1:0] remainder
);
   localparam int             CNT_W = $clog2(CW);
   localparam logic [A_W-1:0] A_VEC = A_W'(MULT_A);

   div_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CW-1:0]   quo_q;
   logic [A_W-1:0]  rem_q;
   logic            done_q;
   logic [A_W:0]    shl;
   logic            take;
   logic [A_W-1:0]  rem_nx;

   // restoring step: shift in next dividend bit, subtract A when it fits
   assign shl    = {rem_q, quo_q[CW-1]};
   assign take   = shl >= {1'b0, A_VEC};
   assign rem_nx = take ? (shl[A_W-1:0] - A_VEC) : shl[A_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DIV_IDLE;
         cnt_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            DIV_IDLE: begin
               if (start) begin
                  quo_q <= dividend;
                  rem_q <= '0;
                  cnt_q <= '0;
                  st_q  <= DIV_RUN;
               end
            end
            default: begin
               quo_q <= {quo_q[CW-2:0], take};
               rem_q <= rem_nx;
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == CNT_W'(CW - 1)) begin
                  st_q   <= DIV_IDLE;
                  done_q <= 1'b1;
               end
            end
         endcase
      end
   end

   assign busy      = (st_q == DIV_RUN);
   assign done      = done_q;
   assign quotient  = quo_q;
   assign remainder = rem_q;

endmodule

// File: rtl/arith_code_unit.sv
module arith_code_unit
   import acu_pkg::*;
#(
   parameter int               FW       = 32,
   parameter int               CW       = 64,
   parameter int               A_W      = 32,
   parameter int               TS_W     = 16,
   parameter int               DEPTH    = 16,
   parameter longint unsigned  MULT_A   = 58659,
   parameter bit               ENC_PIPE = 1'b1,
   localparam int              IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cycle_end,
   output logic [TS_W-1:0]  ts_value,
   input  logic             sig_we,
   input  logic [IDX_W-1:0] sig_waddr,
   input  logic [A_W-1:0]   sig_wdata,
   input  logic             enc_req,
   input  logic [IDX_W-1:0] enc_sel,
   input  logic [FW-1:0]    enc_value,
   output logic             enc_valid,
   output logic [CW-1:0]    enc_word,
   input  logic             chk_start,
   input  logic [IDX_W-1:0] chk_sel,
   input  logic [CW-1:0]    chk_word,
   output logic             chk_busy,
   output logic             chk_done,
   output logic             chk_pass,
   output logic             chk_mismatch,
   output logic [FW-1:0]    chk_value,
   input  logic             err_clr,
   output logic             err_sticky
);
   // elaboration-time parameter checks
   if (is_pow2(MULT_A)) begin : g_bad_pow2
      $error("multiplier must not be a power of two");
   end
   if (MULT_A < 3) begin : g_bad_small
      $error("multiplier must be at least 3");
   end
   if (MULT_A >= (longint'(1) << A_W)) begin : g_bad_width
      $error("multiplier does not fit in A_W bits");
   end
   if (FW + A_W > CW) begin : g_bad_cw
      $error("code width too small for value and multiplier");
   end
   if (TS_W >= FW) begin : g_bad_ts
      $error("stamp width must be below value width");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("table depth must be at least 2");
   end

   logic [TS_W-1:0] ts_q;
   logic [A_W-1:0]  sig_enc;
   logic [A_W-1:0]  sig_chk;
   logic [A_W-1:0]  exp_sig_q;
   logic            div_busy;
   logic            div_done;
   logic [CW-1:0]   div_quo;
   logic [A_W-1:0]  div_rem;
   logic            accept;
   logic            mism;
   logic            release_ok;
   logic            done_q;
   logic            pass_q;
   logic            mism_q;
   logic [FW-1:0]   value_q;
   logic            err_q;

   // iteration stamp
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ts_q <= '0;
      else if (cycle_end)
         ts_q <= ts_q + TS_W'(1);
   end
   assign ts_value = ts_q;

   acu_sig_table #(
      .DEPTH (DEPTH),
      .A_W   (A_W),
      .MULT_A(MULT_A)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sig_we),
      .wr_idx  (sig_waddr),
      .wr_sig  (sig_wdata),
      .rd_idx_a(enc_sel),
      .rd_sig_a(sig_enc),
      .rd_idx_b(chk_sel),
      .rd_sig_b(sig_chk)
   );

   acu_encoder #(
      .FW      (FW),
      .CW      (CW),
      .A_W     (A_W),
      .TS_W    (TS_W),
      .MULT_A  (MULT_A),
      .ENC_PIPE(ENC_PIPE)
   ) u_enc (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (enc_req),
      .value(enc_value),
      .sig  (sig_enc),
      .stamp(ts_q),
      .valid(enc_valid),
      .word (enc_word)
   );

   // check path: strip stamp, divide by A, compare residue
   assign accept = chk_start && !div_busy;

   acu_divider #(
      .CW    (CW),
      .A_W   (A_W),
      .MULT_A(MULT_A)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .dividend (chk_word - CW'(ts_q)),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (div_quo),
      .remainder(div_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         exp_sig_q <= '0;
      else if (accept)
         exp_sig_q <= sig_chk;
   end

   assign mism       = (div_rem != exp_sig_q);
   assign release_ok = !mism && !err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         mism_q  <= 1'b0;
         value_q <= '0;
         err_q   <= 1'b0;
      end else begin
         done_q <= div_done;
         if (div_done) begin
            mism_q  <= mism;
            pass_q  <= release_ok;
            value_q <= release_ok ? div_quo[FW-1:0] : '0;
         end
         if (div_done && mism)
            err_q <= 1'b1;
         else if (err_clr)
            err_q <= 1'b0;
      end
   end

   assign chk_busy     = div_busy;
   assign chk_done     = done_q;
   assign chk_pass     = pass_q;
   assign chk_mismatch = mism_q;
   assign chk_value    = value_q;
   assign err_sticky   = err_q;

endmodule

// File: rtl/acu_checker.sv
module acu_checker #(
   parameter int FW       = 32,
   parameter int TS_W     = 16,
   parameter bit ENC_PIPE = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cycle_end,
   input logic [TS_W-1:0] ts_value,
   input logic            enc_req,
   input logic            enc_valid,
   input logic            chk_busy,
   input logic            chk_done,
   input logic            chk_pass,
   input logic            chk_mismatch,
   input logic [FW-1:0]   chk_value,
   input logic            err_clr,
   input logic            err_sticky
);

   AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> ts_value == $past(ts_value) + TS_W'(1)); // R2

   AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(ts_value)); // R2

   if (ENC_PIPE) begin : g_enc_chk
      AST_ENC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         enc_req |=> enc_valid); // R3
      AST_ENC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         !enc_req |=> !enc_valid); // R3
   end

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chk_busy) |=> chk_done); // R5

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done); // R5

   AST_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |-> !(chk_pass && chk_mismatch)); // R6

   AST_WITHHELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_done && !chk_pass) |-> chk_value == '0); // R6

   AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_done && chk_mismatch) |-> err_sticky); // R8

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !err_clr) |=> err_sticky); // R8

   AST_NO_RELEASE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_done && chk_pass) |-> !$past(err_sticky)); // R8

endmodule

bind arith_code_unit acu_checker #(
   .FW      (FW),
   .TS_W    (TS_W),
   .ENC_PIPE(ENC_PIPE)
) u_acu_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cycle_end   (cycle_end),
   .ts_value    (ts_value),
   .enc_req     (enc_req),
   .enc_valid   (enc_valid),
   .chk_busy    (chk_busy),
   .chk_done    (chk_done),
   .chk_pass    (chk_pass),
   .chk_mismatch(chk_mismatch),
   .chk_value   (chk_value),
   .err_clr     (err_clr),
   .err_sticky  (err_sticky)
);

// File: tb/arith_code_unit_tb.sv
module arith_code_unit_tb;
   localparam int              FW     = 32;
   localparam int              CW     = 64;
   localparam int              A_W    = 32;
   localparam int              TS_W   = 8;
   localparam int              DEPTH  = 16;
   localparam int              IDX_W  = 4;
   localparam longint unsigned MA     = 58659;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cycle_end = 1'b0;
   logic [TS_W-1:0]  ts_value;
   logic             sig_we = 1'b0;
   logic [IDX_W-1:0] sig_waddr = '0;
   logic [A_W-1:0]   sig_wdata = '0;
   logic             enc_req = 1'b0;
   logic [IDX_W-1:0] enc_sel = '0;
   logic [FW-1:0]    enc_value = '0;
   logic             enc_valid;
   logic [CW-1:0]    enc_word;
   logic             chk_start = 1'b0;
   logic [IDX_W-1:0] chk_sel = '0;
   logic [CW-1:0]    chk_word = '0;
   logic             chk_busy;
   logic             chk_done;
   logic             chk_pass;
   logic             chk_mismatch;
   logic [FW-1:0]    chk_value;
   logic             err_clr = 1'b0;
   logic             err_sticky;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   logic [A_W-1:0] mtbl [DEPTH];
   int unsigned mts = 0;

   always #4 clk = ~clk;

   arith_code_unit #(
      .FW(FW), .CW(CW), .A_W(A_W), .TS_W(TS_W), .DEPTH(DEPTH), .MULT_A(MA)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .ts_value(ts_value),
      .sig_we(sig_we), .sig_waddr(sig_waddr), .sig_wdata(sig_wdata),
      .enc_req(enc_req), .enc_sel(enc_sel), .enc_value(enc_value),
      .enc_valid(enc_valid), .enc_word(enc_word),
      .chk_start(chk_start), .chk_sel(chk_sel), .chk_word(chk_word),
      .chk_busy(chk_busy), .chk_done(chk_done), .chk_pass(chk_pass),
      .chk_mismatch(chk_mismatch), .chk_value(chk_value),
      .err_clr(err_clr), .err_sticky(err_sticky)
   );

   function automatic logic [CW-1:0] model_enc(input logic [FW-1:0] v,
                                               input logic [A_W-1:0] s,
                                               input int unsigned d);
      return (CW'(MA) * CW'(v)) + CW'(s) + CW'(d);
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   task automatic write_sig(input int idx, input logic [A_W-1:0] v);
      sig_we = 1'b1; sig_waddr = IDX_W'(idx); sig_wdata = v;
      @(negedge clk);
      sig_we = 1'b0;
      if (v < A_W'(MA)) mtbl[idx] = v;
   endtask

   task automatic pulse_ts(input int n);
      for (int i = 0; i < n; i++) begin
         cycle_end = 1'b1;
         @(negedge clk);
         mts = (mts + 1) % (1 << TS_W);
      end
      cycle_end = 1'b0;
   endtask

   task automatic do_enc(input logic [FW-1:0] v, input int sel, input string req);
      logic [CW-1:0] exp;
      exp = model_enc(v, mtbl[sel], mts);
      enc_req = 1'b1; enc_value = v; enc_sel = IDX_W'(sel);
      @(negedge clk);
      enc_req = 1'b0;
      check(enc_valid == 1'b1, req, CW'(enc_valid), 1);
      check(enc_word == exp, req, enc_word, exp);
   endtask

   // starts a check and waits for the result; returns latency in edges
   task automatic do_chk(input logic [CW-1:0] w, input int sel,
                         input bit late_restart, output int lat);
      chk_start = 1'b1; chk_word = w; chk_sel = IDX_W'(sel);
      @(negedge clk);
      chk_start = 1'b0;
      lat = 0;
      check(chk_busy == 1'b1, "R5 busy", CW'(chk_busy), 1);
      while (!chk_done && lat < 200) begin
         if (late_restart && lat == 5) begin
            chk_start = 1'b1; chk_word = w ^ 64'h1; chk_sel = IDX_W'(sel);
         end else begin
            chk_start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      chk_start = 1'b0;
      check(lat == CW + 1, "R5 latency", CW'(lat), CW + 1);
   endtask

   task automatic expect_pass(input logic [FW-1:0] v, input string req);
      check(chk_pass && !chk_mismatch, req, {chk_pass, chk_mismatch}, 2'b10);
      check(chk_value == v, req, CW'(chk_value), CW'(v));
   endtask

   task automatic expect_fail(input string req);
      check(!chk_pass && chk_mismatch, req, {chk_pass, chk_mismatch}, 2'b01);
      check(chk_value == '0, req, CW'(chk_value), 0);
      check(err_sticky == 1'b1, "R8 set", CW'(err_sticky), 1);
   endtask

   task automatic clear_err();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check(err_sticky == 1'b0, "R8 clear", CW'(err_sticky), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog act=timeout exp=finish");
      summary();
      $finish;
   end

   initial begin
      int lat;
      int unsigned seed_dummy;
      logic [FW-1:0] v;
      logic [CW-1:0] w;
      int sel;
      seed_dummy = $urandom(32'd1234);
      for (int i = 0; i < DEPTH; i++) mtbl[i] = '0;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(ts_value == '0, "R1 stamp", CW'(ts_value), 0);
      check(!enc_valid && !chk_busy && !chk_done, "R1 flags",
            {enc_valid, chk_busy, chk_done}, 0);
      check(!chk_pass && !chk_mismatch && !err_sticky, "R1 result",
            {chk_pass, chk_mismatch, err_sticky}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_enc(32'd5, 3, "R1 table zero");

      // R4 table load, legal and refused writes
      for (int i = 0; i < DEPTH; i++) write_sig(i, A_W'($urandom % 32'(MA)));
      write_sig(0, A_W'(MA - 1));
      do_enc(32'd9, 0, "R4 top legal");
      write_sig(2, A_W'(MA));
      write_sig(2, A_W'(MA + 5));
      do_enc(32'd7, 2, "R4 refused");

      // R2 stamp advance and wrap
      pulse_ts(3);
      check(ts_value == TS_W'(mts), "R2 step", CW'(ts_value), CW'(mts));
      @(negedge clk);
      check(ts_value == TS_W'(mts), "R2 hold", CW'(ts_value), CW'(mts));
      pulse_ts((1 << TS_W) - 1);
      check(ts_value == TS_W'(mts), "R2 wrap", CW'(ts_value), CW'(mts));
      pulse_ts(5);

      // R3 encode corners and random
      do_enc('0, 1, "R3 zero");
      do_enc('1, 0, "R3 max");
      for (int i = 0; i < 12; i++) do_enc($urandom, int'($urandom % DEPTH), "R3 random");

      // R7 round trips
      w = model_enc('1, mtbl[0], mts);
      do_chk(w, 0, 1'b0, lat);
      expect_pass('1, "R7 max");
      w = model_enc('0, mtbl[5], mts);
      do_chk(w, 5, 1'b0, lat);
      expect_pass('0, "R7 zero");
      for (int i = 0; i < 6; i++) begin
         v = $urandom; sel = int'($urandom % DEPTH);
         pulse_ts(int'($urandom % 4));
         do_chk(model_enc(v, mtbl[sel], mts), sel, 1'b0, lat);
         expect_pass(v, "R7 random");
      end

      // R9 restart while busy is ignored
      v = 32'hCAFE_0123;
      do_chk(model_enc(v, mtbl[4], mts), 4, 1'b1, lat);
      expect_pass(v, "R9 first kept");
      begin
         int extra = 0;
         for (int i = 0; i < CW + 8; i++) begin
            @(negedge clk);
            if (chk_done) extra++;
         end
         check(extra == 0, "R9 no extra", CW'(extra), 0);
      end

      // R6 bit flip
      w = model_enc(32'd777, mtbl[6], mts) ^ (64'h1 << ($urandom % 40));
      do_chk(w, 6, 1'b0, lat);
      expect_fail("R6 flip");

      // R8 valid word blocked while sticky
      v = 32'h1234_5678;
      do_chk(model_enc(v, mtbl[7], mts), 7, 1'b0, lat);
      check(!chk_pass && !chk_mismatch, "R8 blocked", {chk_pass, chk_mismatch}, 0);
      check(chk_value == '0, "R8 blocked value", CW'(chk_value), 0);
      check(err_sticky, "R8 held", CW'(err_sticky), 1);
      clear_err();
      do_chk(model_enc(v, mtbl[7], mts), 7, 1'b0, lat);
      expect_pass(v, "R8 after clear");

      // R6 stale stamp
      w = model_enc(32'd42, mtbl[8], mts);
      pulse_ts(1);
      do_chk(w, 8, 1'b0, lat);
      expect_fail("R6 stale stamp");
      clear_err();

      // R6 wrong expected signature
      write_sig(9, A_W'(100));
      write_sig(10, A_W'(101));
      do_chk(model_enc(32'd3, mtbl[9], mts), 10, 1'b0, lat);
      expect_fail("R6 wrong index");
      clear_err();

      summary();
      $finish;
   end

endmodule